// File: doc/BRIEF.md
# Half-Rate Bang-Bang Phase Detector with Two-Way Demultiplexer

This block sits in a clock recovery loop that runs its recovered clock at half the bit rate. Two half-rate clocks drive it. The in-phase clock has both of its edges placed at bit centres. The quadrature clock lags it by a quarter period, so each of its edges falls on the nominal boundary between two bits. Every in-phase edge ends one evaluation window. The window uses three samples: the centre sample from the previous in-phase edge, the boundary sample from the quadrature edge in between, and the centre sample taken now. From these the block decides whether the recovered clock is early or late against the data, or whether no data transition happened.

The centre samples also split the serial stream into two half-rate streams. Rising-edge samples carry the even bits and falling-edge samples carry the odd bits. At each rising in-phase edge both streams are presented together as an ordered pair. The early and late flags go to a loop filter, which is not part of this block.

Top module: `hrbpd_top`

## Requirements
- R1: An active-high asynchronous reset clears every sample register and drives early, late, daOut and dbOut to 0 for as long as it is held.
- R2: At each rising in-phase edge, daOut takes the bit sampled at the previous rising in-phase edge and dbOut takes the bit sampled at the falling edge in between. Read daOut then dbOut on each rising edge and the serial stream comes back in arrival order.
- R3: Evaluations happen on both in-phase edges, with the same rule at each. The first sample is the data taken at the preceding in-phase edge of opposite polarity. The middle sample is the data taken at the quadrature edge between the two in-phase edges. The last sample is the data at the current edge.
- R4: If the first and last samples are equal, early and late are both 0 after that evaluation.
- R5: If the first and last samples differ and the middle sample equals the first, early is 1 and late is 0. This means the data transition arrived after the quadrature edge.
- R6: If the first and last samples differ and the middle sample equals the last, late is 1 and early is 0. This means the data transition arrived before the quadrature edge.
- R7: The flags are registered at the evaluating edge and hold their value until the next in-phase edge, which is one bit time later.
- R8: Early and late are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkI | input | 1 | In-phase half-rate clock, both edges at bit centres |
| clkQ | input | 1 | Quadrature half-rate clock, both edges at bit boundaries |
| rst | input | 1 | Asynchronous reset, active high |
| din | input | 1 | Serial data at twice the clock frequency |
| early | output | 1 | Last evaluation found the clock ahead of the data |
| late | output | 1 | Last evaluation found the clock behind the data |
| daOut | output | 1 | Demultiplexed even bit, updated on rising in-phase edges |
| dbOut | output | 1 | Demultiplexed odd bit, updated on rising in-phase edges |

## Verification
A stale or wrong centre sample shows up at the ports within one bit time. It either raises a flag on a run of equal bits or drops one on an alternating run, and it also swaps or repeats a bit in the daOut/dbOut pair at the next rising edge. A boundary sample taken from the wrong quadrature edge turns early into late for every transition evaluated on that in-phase edge polarity, while the other polarity stays correct. For this reason the sweeps check rising-edge and falling-edge evaluations separately, at several data offsets on each side of the boundary.

// File: rtl/hrbpd_pkg.sv
package hrbpd_pkg;

  // Samples held between in-phase edges, shared by the datapath and the decision logic
  typedef struct packed {
    logic lastA;   // centre sample from the rising in-phase edge
    logic lastB;   // centre sample from the falling in-phase edge
    logic bndAB;   // boundary sample, rising quadrature edge
    logic bndBA;   // boundary sample, falling quadrature edge
  } smpSet_t;

  typedef struct packed {
    logic early;
    logic late;
  } verdict_t;

  localparam int VERDICT_W = $bits(verdict_t);

  // Three-sample bang-bang rule: first, boundary, current
  function automatic verdict_t judge(input logic s0, input logic s1, input logic s2);
    verdict_t v;
    v = '0;
    if (s0 != s2) begin
      if (s1 == s0) v.early = 1'b1;
      else          v.late  = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/hrbpd_sampler.sv
module hrbpd_sampler
  import hrbpd_pkg::*;
(
  input  logic    clkI,
  input  logic    clkQ,
  input  logic    rst,
  input  logic    din,
  output smpSet_t smp,
  output logic    daOut,
  output logic    dbOut
);

  logic lastA, lastB, bndAB, bndBA;
  logic pairA, pairB;

  // Centre samples on both in-phase edges
  always_ff @(posedge clkI or posedge rst) begin
    if (rst) begin
      lastA <= 1'b0;
      pairA <= 1'b0;
      pairB <= 1'b0;
    end else begin
      lastA <= din;
      pairA <= lastA;   // even bit, earlier in time
      pairB <= lastB;   // odd bit that followed it
    end
  end

  always_ff @(negedge clkI or posedge rst) begin
    if (rst) lastB <= 1'b0;
    else     lastB <= din;
  end

  // Boundary samples on both quadrature edges
  always_ff @(posedge clkQ or posedge rst) begin
    if (rst) bndAB <= 1'b0;
    else     bndAB <= din;
  end

  always_ff @(negedge clkQ or posedge rst) begin
    if (rst) bndBA <= 1'b0;
    else     bndBA <= din;
  end

  always_comb begin
    smp.lastA = lastA;
    smp.lastB = lastB;
    smp.bndAB = bndAB;
    smp.bndBA = bndBA;
  end

  assign daOut = pairA;
  assign dbOut = pairB;

endmodule

// File: rtl/hrbpd_decide.sv
module hrbpd_decide
  import hrbpd_pkg::*;
(
  input  logic    clkI,
  input  logic    rst,
  input  logic    din,
  input  smpSet_t smp,
  output logic    early,
  output logic    late
);

  verdict_t vRise, vFall;
  logic [VERDICT_W-1:0] flopP, flopN;
  logic [VERDICT_W-1:0] held;

  // Identical rule on both in-phase edges, each with its own sample triple
  always_comb begin
    vRise = judge(smp.lastB, smp.bndBA, din);
    vFall = judge(smp.lastA, smp.bndAB, din);
  end

  // Dual-edge register: the XOR of the two halves equals the latest verdict
  always_ff @(posedge clkI or posedge rst) begin
    if (rst) flopP <= '0;
    else     flopP <= vRise ^ flopN;
  end

  always_ff @(negedge clkI or posedge rst) begin
    if (rst) flopN <= '0;
    else     flopN <= vFall ^ flopP;
  end

  assign held  = flopP ^ flopN;
  assign early = held[1];
  assign late  = held[0];

  // R8: the flags exclude each other
  assert_exclusive_R8: assert property (@(posedge clkI) disable iff (rst)
    !(early && late));

  // R4: a flag is raised exactly when the two centre samples of the last window differ
  assert_transFall_R4: assert property (@(negedge clkI) disable iff (rst)
    (early || late) == (smp.lastA != smp.lastB));
  assert_transRise_R4: assert property (@(posedge clkI) disable iff (rst)
    (early || late) == (smp.lastA != smp.lastB));

  // R5: early means the boundary sample still matched the older centre sample
  assert_earlyRise_R5: assert property (@(negedge clkI) disable iff (rst)
    early |-> (smp.bndBA == smp.lastB));
  assert_earlyFall_R5: assert property (@(posedge clkI) disable iff (rst)
    early |-> (smp.bndAB == smp.lastA));

  // R6: late means the boundary sample already differed from the older one
  assert_lateRise_R6: assert property (@(negedge clkI) disable iff (rst)
    late |-> (smp.bndBA != smp.lastB));
  assert_lateFall_R6: assert property (@(posedge clkI) disable iff (rst)
    late |-> (smp.bndAB != smp.lastA));

endmodule

// File: rtl/hrbpd_top.sv
module hrbpd_top
  import hrbpd_pkg::*;
(
  input  logic clkI,
  input  logic clkQ,
  input  logic rst,
  input  logic din,
  output logic early,
  output logic late,
  output logic daOut,
  output logic dbOut
);

  smpSet_t smp;

  hrbpd_sampler u_sampler (
    .clkI  (clkI),
    .clkQ  (clkQ),
    .rst   (rst),
    .din   (din),
    .smp   (smp),
    .daOut (daOut),
    .dbOut (dbOut)
  );

  hrbpd_decide u_decide (
    .clkI  (clkI),
    .rst   (rst),
    .din   (din),
    .smp   (smp),
    .early (early),
    .late  (late)
  );

endmodule

// File: tb/sim_hrbpd_top.sv
`timescale 1ns/1ps
module sim_hrbpd_top;

  localparam int NBITS = 32;

  logic clkI = 1'b0;
  logic clkQ = 1'b0;
  logic rst  = 1'b0;
  logic din  = 1'b0;
  logic early, late, daOut, dbOut;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  logic bits [0:NBITS];
  logic [15:0] lfsr = 16'hACE1;

  hrbpd_top u0 (
    .clkI(clkI), .clkQ(clkQ), .rst(rst), .din(din),
    .early(early), .late(late), .daOut(daOut), .dbOut(dbOut)
  );

  // 50 MHz in-phase clock, quadrature copy 5 ns behind
  always #10 clkI = ~clkI;
  initial begin
    #5;
    forever #10 clkQ = ~clkQ;
  end

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic waitTo(input longint t);
    if (t > longint'($time)) #(t - longint'($time));
  endtask

  function automatic logic nextBit(input int kind, input int j);
    case (kind)
      0: return logic'(j[0]);          // alternating
      1: return 1'b1;                  // constant
      2: return logic'(j[1]);          // pairs
      default: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
      end
    endcase
  endfunction

  // Bit j is centred on in-phase edge t0+10j; its transition sits off ns from the boundary
  task automatic runPat(input int kind, input int off);
    longint t0;
    logic [1:0] expF;
    string tag;
    @(posedge clkI);
    t0 = longint'($time);
    bits[0] = din;
    for (int j = 1; j <= NBITS; j++) bits[j] = nextBit(kind, j);
    waitTo(t0 + 5 + off);
    din = bits[1];
    for (int j = 1; j <= NBITS; j++) begin
      waitTo(t0 + 10*j + 1);
      if (bits[j] == bits[j-1]) begin
        expF = 2'b00; tag = "R4";
      end else if (off > 0) begin
        expF = 2'b10; tag = "R5";
      end else begin
        expF = 2'b01; tag = "R6";
      end
      chk($sformatf("%s R3 %s edge kind=%0d off=%0d bit=%0d", tag,
                    (j % 2 == 0) ? "rise" : "fall", kind, off, j), {early, late}, expF);
      chk($sformatf("R8 kind=%0d off=%0d bit=%0d", kind, off, j), {1'b0, early & late}, 2'b00);
      if (j % 2 == 0)
        chk($sformatf("R2 pair kind=%0d off=%0d bit=%0d", kind, off, j),
            {daOut, dbOut}, {bits[j-2], bits[j-1]});
      if (j < NBITS) begin
        waitTo(t0 + 10*j + 5 + off);
        din = bits[j+1];
      end
      waitTo(t0 + 10*j + 9);
      chk($sformatf("R7 hold kind=%0d off=%0d bit=%0d", kind, off, j), {early, late}, expF);
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    longint tr;
    #1 rst = 1'b1;
    #11;
    chk("R1 flags in reset", {early, late}, 2'b00);
    chk("R1 data in reset", {daOut, dbOut}, 2'b00);
    #15 rst = 1'b0;

    for (int k = 0; k < 4; k++) begin
      runPat(k, 1);  runPat(k, 3);  runPat(k, 2);
      runPat(k, -1); runPat(k, -3); runPat(k, -2);
    end

    // Alternating run leaves dbOut at 1, then an asynchronous reset between edges
    runPat(0, 2);
    tr = longint'($time);
    waitTo(tr + 3);
    chk("R2 pair before reset", {daOut, dbOut}, 2'b01);
    rst = 1'b1;
    #1;
    chk("R1 flags async reset", {early, late}, 2'b00);
    chk("R1 data async reset", {daOut, dbOut}, 2'b00);
    #4 rst = 1'b0;
    runPat(3, -2);
    runPat(2, 3);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule